// File: doc/BRIEF.md
# Single-Bus Accumulator Datapath

This block is the datapath of a minimal 8-bit stored-program machine. All transfers between its storage elements use a single 8-bit shared bus. At most one source drives the bus in any cycle. The sources are the program counter, the RAM, the instruction register's address field, the accumulator and the adder/subtractor. The sinks are the memory address register, the instruction register, the accumulator, the B register and the output register. Each of these sinks loads on a rising clock edge when its active-low load line is low.

The datapath decides nothing for itself. A 12-bit control word, produced each cycle by an external sequencer, sets every enable, load, count and ALU-select line. Before a program runs, a separate write port fills the 16-word RAM. The instruction register presents the opcode nibble of the fetched instruction to the sequencer. The output register is the block's only result port.

Instructions are 8 bits wide. The opcode sits in bits 7:4 and the operand address in bits 3:0. A typical sequence runs like this:

1. Move the PC to the MAR.
2. Count the PC.
3. Read the RAM into the IR.
4. Move the IR's address field to the MAR.
5. Read the operand into the accumulator or B.
6. Put the ALU result back into the accumulator.

Top module: `acc_datapath`

## Requirements
- R1: While `rst_n` is low, all of the following are 0: the PC, MAR, IR, accumulator, B and output registers, and therefore `opcode` and `out_val`. Reset asserts asynchronously. It is released on the second rising clock edge after `rst_n` goes high.
- R2: When control bit 0 (count) is high, the PC increments modulo 16 on the rising edge. Otherwise the PC holds its value.
- R3: The control word encoding is as follows. Every load line is active low and every other line is active high.
  - bit 0: PC count
  - bit 1: PC drives bus
  - bit 2: MAR load (active low)
  - bit 3: RAM drives bus
  - bit 4: IR load (active low)
  - bit 5: IR drives bus
  - bit 6: accumulator load (active low)
  - bit 7: accumulator drives bus
  - bit 8: ALU subtract
  - bit 9: ALU drives bus
  - bit 10: B load (active low)
  - bit 11: output load (active low)
- R4: Each register takes the bus value on a rising edge when its load line is low. It keeps its value when its load line is high.
- R5: `opcode` is IR bits 7:4. When the IR drives the bus, the bus carries 0 in bits 7:4 and IR bits 3:0 in bits 3:0.
- R6: The PC and MAR use only bits 3:0 of the bus. When the RAM drives the bus, it drives the word addressed by the MAR.
- R7: The ALU computes accumulator plus B when subtract is low and accumulator minus B when subtract is high. The result wraps modulo 256.
- R8: When no source is enabled, the bus carries 0.
- R9: When `prog_we` is high, `prog_data` is written to RAM at `prog_addr` on the rising edge. RAM contents are not altered by reset.
- R10: The bus carries exactly the value of the single enabled source. At most one of control bits 1, 3, 5, 7 and 9 may be high in a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low clear, released synchronously |
| ctrl | input | 12 | Control word from the external sequencer |
| prog_we | input | 1 | RAM preload write strobe |
| prog_addr | input | 4 | RAM preload address |
| prog_data | input | 8 | RAM preload data |
| opcode | output | 4 | Upper nibble of the instruction register |
| out_val | output | 8 | Output register |

## Verification
The main function is exercised with complete two-instruction sequences: fetch, then load the accumulator, then fetch, then add or subtract from memory. Six operand pairs are used:
- a small sum with no carry;
- a sum that wraps past 255;
- a plain difference;
- a difference that borrows below 0;
- the largest sum, which drops its carry;
- an equal-operand difference that gives zero.

Together these distinguish a correct modulo-256 adder from one that saturates, sign-extends or inverts the subtract select. Checking the opcode after each fetch, and the program counter after the sequence, shows whether the IR and PC load in the right cycles. Directed cases separate the remaining behaviours from their likely faults:
- An idle bus must read zero.
- The IR's high nibble must be masked when it drives the bus.
- The MAR must drop the high bus bits.
- RAM must survive a reset.
- The bus must not OR two sources together.

// File: rtl/accdp_pkg.sv
package accdp_pkg;
  // control word bit positions
  localparam int CW_W        = 12;
  localparam int CW_PC_CNT   = 0;
  localparam int CW_PC_OE    = 1;
  localparam int CW_MAR_LD_N = 2;
  localparam int CW_MEM_OE   = 3;
  localparam int CW_IR_LD_N  = 4;
  localparam int CW_IR_OE    = 5;
  localparam int CW_ACC_LD_N = 6;
  localparam int CW_ACC_OE   = 7;
  localparam int CW_ALU_SUB  = 8;
  localparam int CW_ALU_OE   = 9;
  localparam int CW_B_LD_N   = 10;
  localparam int CW_OUT_LD_N = 11;

  // bus source slots
  localparam int NSRC    = 5;
  localparam int SRC_PC  = 0;
  localparam int SRC_MEM = 1;
  localparam int SRC_IR  = 2;
  localparam int SRC_ACC = 3;
  localparam int SRC_ALU = 4;

  // bus-loaded data registers built by a generate loop
  localparam int NDREG    = 3;
  localparam int DREG_ACC = 0;
  localparam int DREG_B   = 1;
  localparam int DREG_OUT = 2;
endpackage

// File: rtl/accdp_rst_sync.sv
module accdp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_nxt;

  always_comb sync_nxt = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_nxt;
  end

  assign rst_q_n = sync_q[STAGES-1];
endmodule

// File: rtl/accdp_reg.sv
module accdp_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb q_nxt = ld_n ? q : d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_n |=> q == $past(d));
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ld_n |=> $stable(q));
endmodule

// File: rtl/accdp_pc.sv
module accdp_pc #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt,
  output logic [AW-1:0] q
);
  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};
  logic [AW-1:0] q_nxt;

  always_comb q_nxt = cnt ? q + ONE : q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt |=> q == $past(q) + ONE);
  p_pc_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt |=> $stable(q));
endmodule

// File: rtl/accdp_ram.sv
module accdp_ram #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem_q [DEPTH];

  // contents deliberately not reset
  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  always_comb rdata = mem_q[raddr];

  p_prog_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem_q[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/accdp_alu.sv
module accdp_alu #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          sub,
  output logic [DW-1:0] y
);
  always_comb y = sub ? a - b : a + b;
endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
  import accdp_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CW_W-1:0]    ctrl,
  input  logic               prog_we,
  input  logic [AW-1:0]      prog_addr,
  input  logic [DW-1:0]      prog_data,
  output logic [DW-AW-1:0]   opcode,
  output logic [DW-1:0]      out_val
);
  localparam int OPW = DW - AW;
  localparam int DREG_LD [NDREG] = '{CW_ACC_LD_N, CW_B_LD_N, CW_OUT_LD_N};

  logic          rst_q_n;
  logic [DW-1:0] bus;
  logic [AW-1:0] pc_q;
  logic [AW-1:0] mar_q;
  logic [DW-1:0] ir_q;
  logic [DW-1:0] mem_rd;
  logic [DW-1:0] alu_y;
  logic [DW-1:0] acc_q;
  logic [DW-1:0] b_q;
  logic [DW-1:0] dreg_q [NDREG];
  logic [DW-1:0] src    [NSRC];
  logic [NSRC-1:0] src_en;

  accdp_rst_sync #(.STAGES(2)) i_rst (
    .clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n));

  accdp_pc #(.AW(AW)) i_pc (
    .clk(clk), .rst_n(rst_q_n), .cnt(ctrl[CW_PC_CNT]), .q(pc_q));

  accdp_reg #(.W(AW)) i_mar (
    .clk(clk), .rst_n(rst_q_n), .ld_n(ctrl[CW_MAR_LD_N]),
    .d(bus[AW-1:0]), .q(mar_q));

  accdp_reg #(.W(DW)) i_ir (
    .clk(clk), .rst_n(rst_q_n), .ld_n(ctrl[CW_IR_LD_N]),
    .d(bus), .q(ir_q));

  accdp_ram #(.AW(AW), .DW(DW)) i_ram (
    .clk(clk), .rst_n(rst_q_n), .we(prog_we), .waddr(prog_addr),
    .wdata(prog_data), .raddr(mar_q), .rdata(mem_rd));

  for (genvar g = 0; g < NDREG; g++) begin : g_dreg
    accdp_reg #(.W(DW)) i_dreg (
      .clk(clk), .rst_n(rst_q_n), .ld_n(ctrl[DREG_LD[g]]),
      .d(bus), .q(dreg_q[g]));
  end

  assign acc_q   = dreg_q[DREG_ACC];
  assign b_q     = dreg_q[DREG_B];
  assign out_val = dreg_q[DREG_OUT];
  assign opcode  = ir_q[DW-1:AW];

  accdp_alu #(.DW(DW)) i_alu (
    .a(acc_q), .b(b_q), .sub(ctrl[CW_ALU_SUB]), .y(alu_y));

  // bus sources and their enables
  always_comb begin
    src[SRC_PC]     = {{OPW{1'b0}}, pc_q};
    src[SRC_MEM]    = mem_rd;
    src[SRC_IR]     = {{OPW{1'b0}}, ir_q[AW-1:0]};
    src[SRC_ACC]    = acc_q;
    src[SRC_ALU]    = alu_y;
    src_en[SRC_PC]  = ctrl[CW_PC_OE];
    src_en[SRC_MEM] = ctrl[CW_MEM_OE];
    src_en[SRC_IR]  = ctrl[CW_IR_OE];
    src_en[SRC_ACC] = ctrl[CW_ACC_OE];
    src_en[SRC_ALU] = ctrl[CW_ALU_OE];
  end

  // priority-free one-hot multiplexer
  always_comb begin
    bus = '0;
    for (int i = 0; i < NSRC; i++) bus = bus | (src[i] & {DW{src_en[i]}});
  end

  p_one_driver_r10: assert property (@(posedge clk) disable iff (!rst_q_n)
    $countones(src_en) <= 1);
  p_opcode_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    !ctrl[CW_IR_LD_N] |=> opcode == $past(bus[DW-1:AW]));
endmodule

// File: tb/test_acc_datapath.sv
module test_acc_datapath;
  localparam int CLK_PERIOD = 10;
  localparam int Q = CLK_PERIOD / 4;

  localparam logic [11:0] E_PC_CNT = 12'h001;
  localparam logic [11:0] E_PC_OE  = 12'h002;
  localparam logic [11:0] L_MAR    = 12'h004;
  localparam logic [11:0] E_MEM_OE = 12'h008;
  localparam logic [11:0] L_IR     = 12'h010;
  localparam logic [11:0] E_IR_OE  = 12'h020;
  localparam logic [11:0] L_ACC    = 12'h040;
  localparam logic [11:0] E_ACC_OE = 12'h080;
  localparam logic [11:0] E_SUB    = 12'h100;
  localparam logic [11:0] E_ALU_OE = 12'h200;
  localparam logic [11:0] L_B      = 12'h400;
  localparam logic [11:0] L_OUT    = 12'h800;
  localparam logic [11:0] IDLE     = L_MAR | L_IR | L_ACC | L_B | L_OUT;

  // {op1, op2, a, b, sub, expected}
  localparam int NVEC = 6;
  localparam logic [32:0] VEC [NVEC] = '{
    {4'h1, 4'h2, 8'h05, 8'h03, 1'b0, 8'h08},
    {4'h3, 4'h4, 8'hF0, 8'h20, 1'b0, 8'h10},
    {4'h5, 4'h6, 8'h10, 8'h01, 1'b1, 8'h0F},
    {4'h7, 4'h8, 8'h00, 8'h01, 1'b1, 8'hFF},
    {4'h9, 4'hA, 8'hFF, 8'hFF, 1'b0, 8'hFE},
    {4'hB, 4'hC, 8'h7F, 8'h7F, 1'b1, 8'h00}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] ctrl = IDLE;
  logic        prog_we = 1'b0;
  logic [3:0]  prog_addr = '0;
  logic [7:0]  prog_data = '0;
  logic [3:0]  opcode;
  logic [7:0]  out_val;

  int compared = 0;
  int mismatched = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_datapath i_acc_datapath (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .prog_we(prog_we),
    .prog_addr(prog_addr), .prog_data(prog_data),
    .opcode(opcode), .out_val(out_val));

  function automatic logic [11:0] cw(input logic [11:0] en, input logic [11:0] ld);
    return (IDLE & ~ld) | en;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [11:0] w);
    ctrl = w;
    @(posedge clk);
    #Q;
    ctrl = IDLE;
  endtask

  task automatic prog(input logic [3:0] a, input logic [7:0] d);
    prog_we = 1'b1; prog_addr = a; prog_data = d;
    @(posedge clk);
    #Q;
    prog_we = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #Q;
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #Q;
  endtask

  task automatic fetch();
    cyc(cw(E_PC_OE, L_MAR));
    cyc(cw(E_PC_CNT, '0));
    cyc(cw(E_MEM_OE, L_IR));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #Q;
    // R1: reset state
    chk("R1 out during reset", out_val, 8'h00);
    do_reset();
    chk("R1 opcode after reset", {4'h0, opcode}, 8'h00);
    cyc(cw(E_PC_OE, L_OUT));
    chk("R1 pc after reset", out_val, 8'h00);

    // table: fetch/load/fetch/add-or-sub sequences (R3 encoding throughout)
    for (int v = 0; v < NVEC; v++) begin
      logic [3:0] op1, op2;
      logic [7:0] a, b, e;
      logic s;
      {op1, op2, a, b, s, e} = VEC[v];
      do_reset();
      prog(4'h0, {op1, 4'hE});
      prog(4'h1, {op2, 4'hF});
      prog(4'hE, a);
      prog(4'hF, b);
      fetch();
      chk("R5 R3 opcode first fetch", {4'h0, opcode}, {4'h0, op1});
      cyc(cw(E_IR_OE, L_MAR));
      cyc(cw(E_MEM_OE, L_ACC));
      cyc(IDLE);
      fetch();
      chk("R5 R3 opcode second fetch", {4'h0, opcode}, {4'h0, op2});
      cyc(cw(E_IR_OE, L_MAR));
      cyc(cw(E_MEM_OE, L_B));
      cyc(cw(E_ALU_OE | (s ? E_SUB : 12'h000), L_ACC));
      cyc(cw(E_ACC_OE, L_OUT));
      chk("R7 R4 alu result", out_val, e);
      cyc(cw(E_PC_OE, L_OUT));
      chk("R2 pc after two fetches", out_val, 8'h02);
    end

    // R9: RAM survives reset (MAR resets to 0)
    prog(4'h0, 8'h5A);
    prog(4'hA, 8'hC3);
    prog(4'h3, 8'hAB);
    do_reset();
    cyc(cw(E_MEM_OE, L_OUT));
    chk("R9 ram kept across reset", out_val, 8'h5A);

    // R8: idle bus reads zero
    cyc(cw('0, L_OUT));
    chk("R8 idle bus", out_val, 8'h00);

    // R2: wrap after 17 counts, then hold
    for (int k = 0; k < 17; k++) cyc(cw(E_PC_CNT, '0));
    cyc(cw(E_PC_OE, L_OUT));
    chk("R2 pc wrap", out_val, 8'h01);
    cyc(cw(E_MEM_OE, L_ACC));
    cyc(cw(E_PC_OE, L_OUT));
    chk("R2 pc hold", out_val, 8'h01);

    // R4: hold when load high
    cyc(cw(E_ACC_OE, L_OUT));
    chk("R4 acc to out", out_val, 8'h5A);
    cyc(cw(E_PC_OE, '0));
    chk("R4 out holds", out_val, 8'h5A);

    // R5: IR on bus masks upper nibble
    cyc(cw(E_PC_CNT, '0));
    cyc(cw(E_PC_CNT, '0));
    cyc(cw(E_PC_OE, L_MAR));
    cyc(cw(E_MEM_OE, L_IR));
    chk("R5 opcode from ram", {4'h0, opcode}, 8'h0A);
    cyc(cw(E_IR_OE, L_OUT));
    chk("R5 ir on bus", out_val, 8'h0B);

    // R6: MAR takes low nibble of acc (0x5A -> 0xA)
    cyc(cw(E_ACC_OE, L_MAR));
    cyc(cw(E_MEM_OE, L_OUT));
    chk("R6 mar low bits", out_val, 8'hC3);

    // R7 subtract with borrow, R10 single source
    cyc(cw(E_MEM_OE, L_B));
    cyc(cw(E_ALU_OE | E_SUB, L_OUT));
    chk("R7 subtract wrap", out_val, 8'h97);
    cyc(cw(E_ACC_OE, L_OUT));
    chk("R10 single source", out_val, 8'h5A);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule